// File: doc/BRIEF.md
# Byte-Serial Programmable Interval Counter Channel

This block is a single channel of a programmable interval timer. A 16-bit down counter is loaded and read through an 8-bit data path, one byte at a time, always low byte first and high byte second. A separate control-byte strobe programs the counting mode or takes a snapshot of the running count. The channel counts down by one on every clock cycle in which the tick enable is high. The tick enable is usually a divided reference near 1.19 MHz. The output level depends on the selected mode: a one-shot terminal-count flag, a rate generator with a one-tick low pulse, or a square wave.

Writing a low byte halts the channel and forces its output low. The count only restarts when the matching high byte arrives. A snapshot taken with the latch command stays frozen while the live counter keeps running, and it is released once both of its bytes have been read. Control words that ask for features this channel does not provide are refused, and the refusal is reported on an error pulse.

Top module: `byte_interval_counter`

## Requirements
- R1: After reset the output is low, the channel is not counting, the read byte is 0x00 and the error flag is low.
- R2: The control byte is split as bits [7:6] channel select, [5:4] access (00 = latch, 11 = low-then-high word), [3:1] mode, [0] BCD. A control byte whose select is neither this channel (parameter, default 0) nor 3 changes nothing and raises no error.
- R3: A control byte is refused, with cfgErr high for exactly the cycle after the write and with the mode left unchanged, when its select is 3, or when it addresses this channel with access 01 or 10, with a mode other than 0, 2 or 3, or with BCD = 1.
- R4: A data write at the low-byte position replaces count bits [7:0], stops counting, and drives the output low from the next cycle.
- R5: A data write at the high-byte position replaces bits [15:8] and stores the whole value as the period. Counting starts only if that value is nonzero. On start the output is low in mode 0 and high in modes 2 and 3. A zero value leaves the channel stopped. Data writes alternate between the low-byte and high-byte positions, starting at low after reset.
- R6: While counting, the count drops by one on each cycle with tickEn high. Without a tick, or while stopped, the count holds.
- R7: In mode 0 a tick at count 1 brings the count to 0, raises the output and stops the channel.
- R8: In mode 2 a tick at count 1 reloads the period and drives the output low. Any other tick drives it high, so the low pulse lasts one tick interval.
- R9: In mode 3 the output toggles on the tick that leaves count = period/2 (integer halving, when nonzero) and again on the tick at count 1, which reloads the period. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R10: With no snapshot pending, successive reads return the live count's low byte and then its high byte, alternating.
- R11: A latch command (access 00) copies the count into a snapshot. Reads then return the snapshot's low byte and then its high byte, and the snapshot is released after the high byte is read. Counting is not disturbed.
- R12: A latch command that arrives while a snapshot is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count enable, one decrement per high cycle |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlByte | input | 8 | Control byte |
| dataWrEn | input | 1 | Data byte write strobe |
| dataByte | input | 8 | Data byte to load |
| rdEn | input | 1 | Read strobe, advances the read position |
| rdByte | output | 8 | Byte a read returns in this cycle |
| outLevel | output | 1 | Channel output |
| cfgErr | output | 1 | One-cycle pulse for a refused control byte |

## Verification
The embedded assertions watch several invariants on every cycle. A running channel never holds a zero count, and a low-byte write always halts the channel and drops the output. The count and the snapshot only move when a tick, a load or a latch allows it, and a pending snapshot survives until its high byte is read. Mode 0 always fires and stops at terminal count, and a read-back select always flags an error. Other behaviour needs a bench scenario against the cycle-accurate model. That includes the exact output waveforms of the rate and square-wave modes for odd and even periods, and the silent refusal of a second latch. It also includes the byte values seen through interleaved snapshot and live reads, and the fact that refused or foreign control bytes leave the mode untouched.

// File: rtl/bic_pkg.sv
package bic_pkg;

  typedef enum logic [2:0] {
    CM_TERMINAL = 3'd0,
    CM_RATE     = 3'd2,
    CM_SQUARE   = 3'd3
  } cntMode_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic     wrLow;     // load low byte, halt
    logic     wrHigh;    // load high byte, arm period
    logic     snap;      // copy count into snapshot
    logic     selLatch;  // read mux takes snapshot
    logic     selHigh;   // read mux takes high byte
    cntMode_e mode;      // active counting mode
  } dpCmd_t;

endpackage

// File: rtl/bic_ctrl.sv
module bic_ctrl
  import bic_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int CHAN_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrlWrEn,
  input  logic [BUS_W-1:0] ctrlByte,
  input  logic             dataWrEn,
  input  logic             rdEn,
  output dpCmd_t           cmd,
  output logic             cfgErr
);

  localparam int SEL_HI = BUS_W - 1;
  localparam int SEL_LO = BUS_W - 2;
  localparam int ACC_HI = BUS_W - 3;
  localparam int ACC_LO = BUS_W - 4;
  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam logic [1:0] SEL_MINE     = 2'(CHAN_ID);
  localparam logic [1:0] ACC_LATCH    = 2'b00;
  localparam logic [1:0] ACC_WORD     = 2'b11;

  logic [1:0] selField, accField;
  logic [2:0] modeField;
  logic       bcdField;

  assign selField  = ctrlByte[SEL_HI:SEL_LO];
  assign accField  = ctrlByte[ACC_HI:ACC_LO];
  assign modeField = ctrlByte[3:1];
  assign bcdField  = ctrlByte[0];

  cntMode_e modeQ;
  logic     wrHighQ, rdHighQ, latchPendQ, errQ;

  logic isMine, isReadBack, latchCmd, progCmd, modeOk, progOk;
  logic errNext, snapNow, releaseNow;

  always_comb begin
    isMine     = ctrlWrEn && (selField == SEL_MINE);
    isReadBack = ctrlWrEn && (selField == SEL_READBACK);
    latchCmd   = isMine && (accField == ACC_LATCH);
    progCmd    = isMine && (accField != ACC_LATCH);
    modeOk     = (modeField == 3'd0) || (modeField == 3'd2) || (modeField == 3'd3);
    progOk     = (accField == ACC_WORD) && modeOk && !bcdField;
    errNext    = isReadBack || (progCmd && !progOk);
    snapNow    = latchCmd && !latchPendQ;
    releaseNow = rdEn && latchPendQ && rdHighQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ      <= CM_TERMINAL;
      wrHighQ    <= 1'b0;
      rdHighQ    <= 1'b0;
      latchPendQ <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      errQ <= errNext;
      if (progCmd && progOk) modeQ <= cntMode_e'(modeField);
      if (dataWrEn) wrHighQ <= !wrHighQ;
      if (snapNow) begin
        latchPendQ <= 1'b1;
        rdHighQ    <= 1'b0;
      end else begin
        if (releaseNow) latchPendQ <= 1'b0;
        if (rdEn) rdHighQ <= !rdHighQ;
      end
    end
  end

  always_comb begin
    cmd.wrLow    = dataWrEn && !wrHighQ;
    cmd.wrHigh   = dataWrEn && wrHighQ;
    cmd.snap     = snapNow;
    cmd.selLatch = latchPendQ;
    cmd.selHigh  = rdHighQ;
    cmd.mode     = modeQ;
  end

  assign cfgErr = errQ;

  AST_READBACK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWrEn && ctrlByte[SEL_HI:SEL_LO] == SEL_READBACK) |=> cfgErr); // R3
  AST_SNAPSHOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.selLatch && !(rdEn && cmd.selHigh)) |=> cmd.selLatch); // R12
  AST_SNAPSHOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.selLatch && rdEn && cmd.selHigh) |=> !cmd.selLatch); // R11

endmodule

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  dpCmd_t           cmd,
  input  logic [BUS_W-1:0] dataByte,
  output logic [BUS_W-1:0] rdByte,
  output logic             outLevel
);

  localparam int LANES = 2;
  localparam int CNT_W = LANES * BUS_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ, periodQ, snapQ;
  logic             runQ, outQ;

  logic [LANES-1:0] laneWr;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] halfPt;

  assign laneWr = {cmd.wrHigh, cmd.wrLow};
  assign halfPt = periodQ >> 1;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign loadVal[l*BUS_W +: BUS_W] = laneWr[l] ? dataByte : countQ[l*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ  <= '0;
      periodQ <= '0;
      snapQ   <= '0;
      runQ    <= 1'b0;
      outQ    <= 1'b0;
    end else begin
      if (cmd.snap) snapQ <= countQ;
      if (cmd.wrLow) begin
        countQ <= loadVal;
        runQ   <= 1'b0;
        outQ   <= 1'b0;
      end else if (cmd.wrHigh) begin
        countQ  <= loadVal;
        periodQ <= loadVal;
        runQ    <= (loadVal != '0);
        outQ    <= (loadVal != '0) && (cmd.mode != CM_TERMINAL);
      end else if (tickEn && runQ) begin
        unique case (cmd.mode)
          CM_TERMINAL: begin
            countQ <= countQ - ONE;
            if (countQ == ONE) begin
              outQ <= 1'b1;
              runQ <= 1'b0;
            end
          end
          CM_RATE: begin
            if (countQ == ONE) begin
              countQ <= periodQ;
              outQ   <= 1'b0;
            end else begin
              countQ <= countQ - ONE;
              outQ   <= 1'b1;
            end
          end
          CM_SQUARE: begin
            if (countQ == ONE) begin
              countQ <= periodQ;
              outQ   <= !outQ;
            end else begin
              countQ <= countQ - ONE;
              if (halfPt != '0 && countQ == halfPt + ONE) outQ <= !outQ;
            end
          end
          default: countQ <= countQ;
        endcase
      end
    end
  end

  logic [CNT_W-1:0] rdSrc;
  assign rdSrc    = cmd.selLatch ? snapQ : countQ;
  assign rdByte   = cmd.selHigh ? rdSrc[CNT_W-1 -: BUS_W] : rdSrc[BUS_W-1:0];
  assign outLevel = outQ;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    runQ |-> (countQ != '0)); // R6
  AST_LOW_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.wrLow |=> (!runQ && !outLevel)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !cmd.wrLow && !cmd.wrHigh) |=> $stable(countQ)); // R6
  AST_TERMINAL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.mode == CM_TERMINAL && runQ && tickEn && !cmd.wrLow && !cmd.wrHigh && countQ == ONE)
      |=> (outLevel && !runQ)); // R7
  AST_SNAPSHOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.snap |=> $stable(snapQ)); // R11

endmodule

// File: rtl/byte_interval_counter.sv
module byte_interval_counter
  import bic_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int CHAN_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             ctrlWrEn,
  input  logic [BUS_W-1:0] ctrlByte,
  input  logic             dataWrEn,
  input  logic [BUS_W-1:0] dataByte,
  input  logic             rdEn,
  output logic [BUS_W-1:0] rdByte,
  output logic             outLevel,
  output logic             cfgErr
);

  dpCmd_t cmd;

  bic_ctrl #(.BUS_W(BUS_W), .CHAN_ID(CHAN_ID)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrlWrEn (ctrlWrEn),
    .ctrlByte (ctrlByte),
    .dataWrEn (dataWrEn),
    .rdEn     (rdEn),
    .cmd      (cmd),
    .cfgErr   (cfgErr)
  );

  bic_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .cmd      (cmd),
    .dataByte (dataByte),
    .rdByte   (rdByte),
    .outLevel (outLevel)
  );

endmodule

// File: tb/byte_interval_counter_bench.sv
module byte_interval_counter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlByte = '0;
  logic       dataWrEn = 1'b0;
  logic [7:0] dataByte = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdByte;
  logic       outLevel;
  logic       cfgErr;

  int nChk = 0;
  int nFail = 0;
  bit comparing = 1'b0;
  bit finished = 1'b0;

  always #4 clk = !clk;

  byte_interval_counter u_byte_interval_counter (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn),
    .ctrlWrEn(ctrlWrEn), .ctrlByte(ctrlByte),
    .dataWrEn(dataWrEn), .dataByte(dataByte),
    .rdEn(rdEn), .rdByte(rdByte), .outLevel(outLevel), .cfgErr(cfgErr)
  );

  // Behavioural reference model
  logic [15:0] mCount, mPeriod, mSnap;
  bit mRun, mOut, mSnapOn, mRdHi, mWrHi, mErr;
  int mMode;

  always @(posedge clk) begin
    if (!rst_n) begin
      mCount = 0; mPeriod = 0; mSnap = 0;
      mRun = 0; mOut = 0; mSnapOn = 0; mRdHi = 0; mWrHi = 0; mErr = 0; mMode = 0;
    end else begin
      int newMode;
      newMode = mMode;
      mErr = 0;
      if (rdEn) begin
        if (mSnapOn && mRdHi) mSnapOn = 0;
        mRdHi = !mRdHi;
      end
      if (ctrlWrEn) begin
        int sel, acc, md, bcd;
        sel = ctrlByte[7:6]; acc = ctrlByte[5:4]; md = ctrlByte[3:1]; bcd = ctrlByte[0];
        if (sel == 3) mErr = 1;
        else if (sel == 0) begin
          if (acc == 0) begin
            if (!mSnapOn) begin mSnap = mCount; mSnapOn = 1; mRdHi = 0; end
          end else if (acc == 3 && (md == 0 || md == 2 || md == 3) && bcd == 0) newMode = md;
          else mErr = 1;
        end
      end
      if (dataWrEn) begin
        if (mWrHi) begin
          mCount = {dataByte, mCount[7:0]};
          mPeriod = mCount;
          mRun = (mCount != 0);
          mOut = mRun && (mMode != 0);
        end else begin
          mCount = {mCount[15:8], dataByte};
          mRun = 0; mOut = 0;
        end
        mWrHi = !mWrHi;
      end else if (tickEn && mRun) begin
        if (mMode == 0) begin
          if (mCount == 1) begin mCount = 0; mOut = 1; mRun = 0; end
          else mCount = mCount - 1;
        end else if (mMode == 2) begin
          if (mCount == 1) begin mCount = mPeriod; mOut = 0; end
          else begin mCount = mCount - 1; mOut = 1; end
        end else begin
          if (mCount == 1) begin mCount = mPeriod; mOut = !mOut; end
          else begin
            if ((mPeriod >> 1) != 0 && mCount == (mPeriod >> 1) + 1) mOut = !mOut;
            mCount = mCount - 1;
          end
        end
      end
      mMode = newMode;
    end
  end

  function automatic logic [7:0] modelRd();
    logic [15:0] src;
    src = mSnapOn ? mSnap : mCount;
    return mRdHi ? src[15:8] : src[7:0];
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rst_n) begin
      chk("R5/R7/R8/R9 outLevel vs model", {15'd0, outLevel}, {15'd0, mOut});
      chk("R6/R10/R11 rdByte vs model", {8'd0, rdByte}, {8'd0, modelRd()});
      chk("R2/R3 cfgErr vs model", {15'd0, cfgErr}, {15'd0, mErr});
    end
  end

  task automatic ctrlWr(input logic [7:0] b, output logic err);
    @(negedge clk); ctrlWrEn = 1; ctrlByte = b;
    @(negedge clk); ctrlWrEn = 0; err = cfgErr;
  endtask

  task automatic dataWr(input logic [7:0] b);
    @(negedge clk); dataWrEn = 1; dataByte = b;
    @(negedge clk); dataWrEn = 0;
  endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk); v = rdByte; rdEn = 1;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tickEn = 1;
    repeat (n) @(negedge clk);
    tickEn = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic e;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    comparing = 1;
    chk("R1 reset outLevel", {15'd0, outLevel}, 16'd0);
    chk("R1 reset rdByte", {8'd0, rdByte}, 16'd0);
    chk("R1 reset cfgErr", {15'd0, cfgErr}, 16'd0);

    // Mode 0, count 5
    ctrlWr(8'h30, e); chk("R3 valid word no error", {15'd0, e}, 16'd0);
    dataWr(8'h05); dataWr(8'h00);
    chk("R5 mode 0 starts low", {15'd0, outLevel}, 16'd0);
    ticks(2);
    readByte(v); chk("R10 live low byte", {8'd0, v}, 16'h03);
    readByte(v); chk("R10 live high byte", {8'd0, v}, 16'h00);
    ticks(2); chk("R7 still low at count 1", {15'd0, outLevel}, 16'd0);
    ticks(1); chk("R7 high at terminal", {15'd0, outLevel}, 16'd1);
    ticks(3); readByte(v); chk("R7 stopped at zero", {8'd0, v}, 16'h00);
    readByte(v);

    // Refused and foreign control bytes
    ctrlWr(8'hC0, e); chk("R3 read-back select", {15'd0, e}, 16'd1);
    ctrlWr(8'h10, e); chk("R3 access 01", {15'd0, e}, 16'd1);
    ctrlWr(8'h32, e); chk("R3 mode 1", {15'd0, e}, 16'd1);
    ctrlWr(8'h31, e); chk("R3 BCD set", {15'd0, e}, 16'd1);
    ctrlWr(8'h3A, e); chk("R3 mode 5", {15'd0, e}, 16'd1);
    ctrlWr(8'h74, e); chk("R2 other channel no error", {15'd0, e}, 16'd0);
    dataWr(8'h03); dataWr(8'h00);
    ticks(2); chk("R2 mode kept at 0 (low)", {15'd0, outLevel}, 16'd0);
    ticks(1); chk("R3 mode kept at 0 (fires)", {15'd0, outLevel}, 16'd1);

    // Mode 2, period 4
    ctrlWr(8'h34, e);
    dataWr(8'h04); dataWr(8'h00);
    chk("R5 mode 2 starts high", {15'd0, outLevel}, 16'd1);
    ticks(3); chk("R8 high before reload", {15'd0, outLevel}, 16'd1);
    ticks(1); chk("R8 low pulse at reload", {15'd0, outLevel}, 16'd0);
    ticks(1); chk("R8 high after pulse", {15'd0, outLevel}, 16'd1);
    ticks(9);

    // Mode 3, period 5 then 4
    ctrlWr(8'h36, e);
    dataWr(8'h05); dataWr(8'h00);
    chk("R9 starts high", {15'd0, outLevel}, 16'd1);
    ticks(2); chk("R9 high for ceil half", {15'd0, outLevel}, 16'd1);
    ticks(1); chk("R9 low after half", {15'd0, outLevel}, 16'd0);
    ticks(2); chk("R9 high after reload", {15'd0, outLevel}, 16'd1);
    dataWr(8'h04); dataWr(8'h00);
    ticks(11);

    // Low-byte write halts, then high-byte restarts
    dataWr(8'h10);
    chk("R4 output forced low", {15'd0, outLevel}, 16'd0);
    ticks(3);
    readByte(v); chk("R4 count halted", {8'd0, v}, 16'h10);
    readByte(v);
    dataWr(8'h00);
    ticks(4);
    readByte(v); chk("R6 restarted and counted", {8'd0, v}, 16'h0C);
    readByte(v);

    // Zero load leaves channel stopped
    dataWr(8'h00); dataWr(8'h00);
    ticks(3);
    readByte(v); chk("R5 zero load no count", {8'd0, v}, 16'h00);
    readByte(v);
    chk("R5 zero load output low", {15'd0, outLevel}, 16'd0);

    // Snapshot handling
    ctrlWr(8'h34, e);
    dataWr(8'h23); dataWr(8'h01);
    ticks(3);
    ctrlWr(8'h00, e); chk("R11 latch no error", {15'd0, e}, 16'd0);
    ticks(2);
    readByte(v); chk("R11 snapshot low", {8'd0, v}, 16'h20);
    ctrlWr(8'h00, e);
    ticks(1);
    readByte(v); chk("R12 second latch ignored", {8'd0, v}, 16'h01);
    readByte(v); chk("R11 released, live low", {8'd0, v}, 16'h1D);
    readByte(v); chk("R10 live high", {8'd0, v}, 16'h01);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule